// File: doc/BRIEF.md
# Memory Fault Status Capture Unit

This block keeps a sticky record of why a processor core's memory protection logic rejected an access. The core reports four kinds of fault as single-cycle (or longer) pulses: a denied instruction fetch, a denied data load or store, a denied push while stacking context on exception entry, and a denied pop while unstacking on exception return. Each sets its own flag in an 8-bit status byte, and the flag stays set until software clears it.

Only a denied data load or store comes with a usable address. For that case the unit copies the address presented with the event into a fault address register and raises an address-valid flag. The other three fault kinds leave both untouched. Software reads the status byte or the address through a small register port and clears flags by writing ones to them. Clearing the address-valid flag lets a handler that has escalated the fault mark the held address as stale.

Top module: `memFaultCapture`

## Requirements
- R1: On synchronous reset (rst high at a clock edge) every status bit, the address-valid flag and the fault address register become 0.
- R2: Status byte layout: bit 0 fetch violation, bit 1 data violation, bit 3 unstacking fault, bit 4 stacking fault, bit 7 address valid; bits 2, 5 and 6 always read 0.
- R3: dataViolation high at an edge sets status bit 1 and bit 7, and loads the fault address register with faultAddr from that same edge. All three are visible after the edge.
- R4: fetchViolation high at an edge sets status bit 0 and changes neither the fault address register nor bit 7.
- R5: stackFault high at an edge sets status bit 4 without touching the fault address register or bit 7. A stacking fault held over several cycles leaves a single flag that one clear removes.
- R6: unstackFault high at an edge sets status bit 3 without touching the fault address register or bit 7.
- R7: With wrEn high and rdSel 0, each 1 in wrData clears the matching implemented status bit, each 0 leaves it unchanged, and ones at bits 2, 5 and 6 have no effect. With no event and no clear, every flag holds its value.
- R8: When a fault event and a software clear of the same flag meet at one edge, the flag ends up set.
- R9: A data violation while bit 7 is already 1 replaces the fault address register with the newer address.
- R10: rdData is a pure selection of registered state: rdSel 0 gives the status byte zero-extended, rdSel 1 gives the fault address register. Reading changes nothing.
- R11: Writing 1 to bit 7 drops the address-valid flag and leaves the fault address register unchanged. With wrEn high and rdSel 1 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchViolation | input | 1 | Denied instruction fetch event |
| dataViolation | input | 1 | Denied data load/store event |
| stackFault | input | 1 | Denied access during exception-entry stacking |
| unstackFault | input | 1 | Denied access during exception-return unstacking |
| faultAddr | input | ADDR_W | Address of the denied data access, valid with dataViolation |
| wrEn | input | 1 | Register write strobe (acts on the status byte only when rdSel is 0) |
| rdSel | input | 1 | Register select: 0 status byte, 1 fault address |
| wrData | input | 8 | Write-one-to-clear mask for the status byte |
| rdData | output | ADDR_W | Selected register value |
| statusByte | output | 8 | Current status byte |
| faultAddrReg | output | ADDR_W | Current fault address register |
| addrValid | output | 1 | Fault address register holds a current address |

## Verification
Every event and every clear takes effect at the first rising edge where it is sampled, so the status byte, addrValid and faultAddrReg are due one cycle after the stimulus and rdData follows them with no added register. The bench drives inputs at the falling edge and samples 1 ns after the next rising edge. It then flips rdSel and samples rdData again within the same cycle. A software model updates once per edge, and every check compares against the state of that model after the edge.

// File: rtl/mfcPkg.sv
package mfcPkg;
  localparam int STAT_W     = 8;
  localparam int BIT_FETCH  = 0;
  localparam int BIT_DATA   = 1;
  localparam int BIT_UNSTK  = 3;
  localparam int BIT_STK    = 4;
  localparam int BIT_VALID  = 7;
  localparam logic [STAT_W-1:0] IMPL_MASK =
    (STAT_W'(1) << BIT_FETCH) | (STAT_W'(1) << BIT_DATA) |
    (STAT_W'(1) << BIT_UNSTK) | (STAT_W'(1) << BIT_STK)  |
    (STAT_W'(1) << BIT_VALID);

  typedef struct packed {
    logic [STAT_W-1:0] setMask;
    logic [STAT_W-1:0] clrMask;
    logic              captureAddr;
  } strobeT;
endpackage

// File: rtl/mfcCtrl.sv
module mfcCtrl
  import mfcPkg::*;
(
  input  logic              fetchViolation,
  input  logic              dataViolation,
  input  logic              stackFault,
  input  logic              unstackFault,
  input  logic              wrEn,
  input  logic              rdSel,
  input  logic [STAT_W-1:0] wrData,
  output strobeT            strobe
);
  logic [STAT_W-1:0] eventVec;
  logic              statusWrite;

  always_comb begin
    eventVec            = '0;
    eventVec[BIT_FETCH] = fetchViolation;
    eventVec[BIT_DATA]  = dataViolation;
    eventVec[BIT_UNSTK] = unstackFault;
    eventVec[BIT_STK]   = stackFault;
    eventVec[BIT_VALID] = dataViolation;
  end

  assign statusWrite = wrEn && !rdSel;

  always_comb begin
    strobe.setMask     = eventVec & IMPL_MASK;
    strobe.clrMask     = statusWrite ? (wrData & IMPL_MASK) : '0;
    strobe.captureAddr = dataViolation;
  end
endmodule

// File: rtl/mfcDatapath.sv
module mfcDatapath
  import mfcPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              rdSel,
  output logic [STAT_W-1:0] statusVec,
  output logic [ADDR_W-1:0] addrQ,
  output logic [ADDR_W-1:0] rdData
);
  localparam int PAD_W = ADDR_W - STAT_W;

  for (genvar b = 0; b < STAT_W; b++) begin : gFlag
    if (IMPL_MASK[b]) begin : gImpl
      logic flagQ;
      always_ff @(posedge clk) begin
        if (rst) flagQ <= 1'b0;
        else     flagQ <= strobe.setMask[b] | (flagQ & ~strobe.clrMask[b]);
      end
      assign statusVec[b] = flagQ;

      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        strobe.setMask[b] |=> statusVec[b]);
      // R7
      sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe.setMask[b] && !strobe.clrMask[b]) |=> $stable(statusVec[b]));
    end else begin : gResv
      assign statusVec[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     addrQ <= '0;
    else if (strobe.captureAddr) addrQ <= faultAddr;
  end

  assign rdData = rdSel ? addrQ : {{PAD_W{1'b0}}, statusVec};

  // R3
  addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.captureAddr |=> (addrQ == $past(faultAddr)) && statusVec[BIT_VALID]);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.captureAddr |=> $stable(addrQ));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (statusVec == '0) && (addrQ == '0));
endmodule

// File: rtl/memFaultCapture.sv
module memFaultCapture
  import mfcPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchViolation,
  input  logic              dataViolation,
  input  logic              stackFault,
  input  logic              unstackFault,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              wrEn,
  input  logic              rdSel,
  input  logic [7:0]        wrData,
  output logic [ADDR_W-1:0] rdData,
  output logic [7:0]        statusByte,
  output logic [ADDR_W-1:0] faultAddrReg,
  output logic              addrValid
);
  strobeT strobe;

  mfcCtrl uCtrl (
    .fetchViolation (fetchViolation),
    .dataViolation  (dataViolation),
    .stackFault     (stackFault),
    .unstackFault   (unstackFault),
    .wrEn           (wrEn),
    .rdSel          (rdSel),
    .wrData         (wrData),
    .strobe         (strobe)
  );

  mfcDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .faultAddr (faultAddr),
    .rdSel     (rdSel),
    .statusVec (statusByte),
    .addrQ     (faultAddrReg),
    .rdData    (rdData)
  );

  assign addrValid = statusByte[BIT_VALID];

  // R11
  sw_write_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && rdSel && !dataViolation) |=> $stable(faultAddrReg));
  // R5
  stack_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (stackFault && !dataViolation && !addrValid) |=> !addrValid);
endmodule

// File: tb/sim_memFaultCapture.sv
`timescale 1ns/1ps
module sim_memFaultCapture;
  localparam int ADDR_W = 32;
  logic clk = 1'b0;
  logic rst, fetchViolation, dataViolation, stackFault, unstackFault;
  logic [ADDR_W-1:0] faultAddr;
  logic wrEn, rdSel;
  logic [7:0] wrData;
  logic [ADDR_W-1:0] rdData, faultAddrReg;
  logic [7:0] statusByte;
  logic addrValid;

  int total = 0;
  int bad = 0;
  logic [7:0] expStat;
  logic [ADDR_W-1:0] expAddr;
  bit finished = 0;

  always #2.5 clk = ~clk;

  memFaultCapture #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .fetchViolation(fetchViolation),
    .dataViolation(dataViolation), .stackFault(stackFault),
    .unstackFault(unstackFault), .faultAddr(faultAddr), .wrEn(wrEn),
    .rdSel(rdSel), .wrData(wrData), .rdData(rdData),
    .statusByte(statusByte), .faultAddrReg(faultAddrReg), .addrValid(addrValid)
  );

  task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of one edge from the requirements
  task automatic modelEdge(input logic [3:0] ev, input logic we, input logic sel,
                           input logic [7:0] wd, input logic [ADDR_W-1:0] a);
    logic [7:0] setM, clrM;
    setM = {ev[1], 2'b00, ev[2], ev[3], 1'b0, ev[1], ev[0]};
    clrM = (we && !sel) ? (wd & 8'b1001_1011) : 8'h00;
    expStat = setM | (expStat & ~clrM);
    if (ev[1]) expAddr = a;
  endtask

  // ev: [0] fetch, [1] data, [2] stack, [3] unstack
  task automatic step(input logic [3:0] ev, input logic we, input logic sel,
                      input logic [7:0] wd, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    fetchViolation = ev[0]; dataViolation = ev[1];
    stackFault = ev[2]; unstackFault = ev[3];
    wrEn = we; rdSel = sel; wrData = wd; faultAddr = a;
    @(posedge clk);
    #1;
    modelEdge(ev, we, sel, wd, a);
    fetchViolation = 0; dataViolation = 0; stackFault = 0; unstackFault = 0;
    wrEn = 0;
  endtask

  task automatic checkAll();
    check("R4 fetch flag",    ADDR_W'(statusByte[0]), ADDR_W'(expStat[0]));
    check("R3 data flag",     ADDR_W'(statusByte[1]), ADDR_W'(expStat[1]));
    check("R6 unstack flag",  ADDR_W'(statusByte[3]), ADDR_W'(expStat[3]));
    check("R5 stack flag",    ADDR_W'(statusByte[4]), ADDR_W'(expStat[4]));
    check("R11 valid flag",   ADDR_W'(addrValid),     ADDR_W'(expStat[7]));
    check("R2 reserved bits", ADDR_W'({statusByte[6:5], statusByte[2]}), '0);
    check("R9 fault address", faultAddrReg, expAddr);
    rdSel = 1'b0; #0.5;
    check("R10 read status",  rdData, ADDR_W'(expStat));
    rdSel = 1'b1; #0.5;
    check("R10 read address", rdData, expAddr);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; fetchViolation = 0; dataViolation = 0; stackFault = 0;
    unstackFault = 0; faultAddr = '0; wrEn = 0; rdSel = 0; wrData = '0;
    // seed non-zero state before reset by holding events
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    dataViolation = 1; fetchViolation = 1; faultAddr = 32'hDEAD_BEEF;
    @(negedge clk); dataViolation = 0; fetchViolation = 0; rst = 1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 status after reset", ADDR_W'(statusByte), '0);
    check("R1 address after reset", faultAddrReg, '0);
    check("R1 valid after reset", ADDR_W'(addrValid), '0);
    @(negedge clk); rst = 0;
    expStat = '0; expAddr = '0;

    // R5 stacking fault held over several cycles: one flag, one clear
    for (int k = 0; k < 3; k++) step(4'b0100, 0, 0, 8'h00, 32'h1111_0000 + k);
    check("R5 stack flag set", ADDR_W'(statusByte), ADDR_W'(8'h10));
    check("R5 no address", faultAddrReg, '0);
    step(4'b0000, 1, 0, 8'h10, '0);
    check("R5 single clear", ADDR_W'(statusByte), '0);

    // R3 then R9 overwrite, R11 valid clear keeps address
    step(4'b0010, 0, 0, 8'h00, 32'hA000_0004);
    check("R3 address", faultAddrReg, 32'hA000_0004);
    check("R3 status", ADDR_W'(statusByte), ADDR_W'(8'h82));
    step(4'b0010, 0, 0, 8'h00, 32'hB000_0008);
    check("R9 newer address", faultAddrReg, 32'hB000_0008);
    step(4'b0000, 1, 0, 8'h80, '0);
    check("R11 valid dropped", ADDR_W'(addrValid), '0);
    check("R11 address kept", faultAddrReg, 32'hB000_0008);
    step(4'b0000, 1, 1, 8'hFF, '0);
    check("R11 write with rdSel 1 ignored", ADDR_W'(statusByte), ADDR_W'(8'h02));

    // R8 set beats clear at the same edge
    step(4'b1111, 1, 0, 8'hFF, 32'hC0C0_0010);
    check("R8 set wins", ADDR_W'(statusByte), ADDR_W'(8'h9B));
    // R7 zeros leave flags, reserved ones ignored
    step(4'b0000, 1, 0, 8'h64, '0);
    check("R7 reserved and zero bits", ADDR_W'(statusByte), ADDR_W'(8'h9B));
    step(4'b0000, 1, 0, 8'h09, '0);
    check("R7 partial clear", ADDR_W'(statusByte), ADDR_W'(8'h92));
    // R10 reads have no side effects
    for (int k = 0; k < 4; k++) step(4'b0000, 0, k[0], 8'h00, '0);
    check("R10 state after reads", ADDR_W'(statusByte), ADDR_W'(8'h92));

    // sweep: every event combination against every write mask and select
    for (int e = 0; e < 16; e++) begin
      for (int w = 0; w < 256; w++) begin
        step(4'(e), 1'b1, w[0] & w[3], 8'(w),
             32'h9E37_79B9 * (e * 256 + w) + 32'h0000_1000);
        checkAll();
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule